// File: doc/BRIEF.md
# Supply Reset Sequencer with Qualified Manual Reset

This block produces the active-low system reset for a chip domain. It combines two inputs. The first is a digital "supply is above its threshold" flag from an external comparator. The second is an active-low push-button or manual reset pin. While either condition is present, reset stays asserted. Once both have cleared, reset is held for a further fixed number of oscillator cycles before it is released. A drop of the supply flag during that hold, or a new manual press, discards the partial count. The next release then waits for a complete fresh count.

The block runs from a free-running oscillator clock. Both inputs are asynchronous to that clock and pass through two-flop synchronisers. The manual input is also pulse-width qualified, so a glitch shorter than the minimum width does not reset the system. A second output gives the watchdog logic a high-active "reset in progress" status.

Top module: `rst_seq_top`

## Requirements
- R1: When the supply flag goes low, the reset output goes low (asserted) on the third rising clock edge after the change. No timer is involved.
- R2: When the supply flag goes high with the manual input released, the reset output goes high after exactly STRETCH_CYCLES+3 rising edges. It stays low on every edge before that.
- R3: If the supply flag drops during the stretch, the count is cleared and the output never releases in between. Release then follows exactly STRETCH_CYCLES+3 edges after the supply flag returns.
- R4: A manual input held low (logic 0) for at least MIN_LOW_CYCLES clock cycles asserts reset on rising edge MIN_LOW_CYCLES+3 after the press begins.
- R5: A manual low pulse shorter than MIN_LOW_CYCLES cycles leaves the reset output high throughout.
- R6: While a qualified manual press is held, the stretch counter stays at zero. On release of the manual input (return to 1), reset goes high exactly STRETCH_CYCLES+4 edges later, whatever the press length.
- R7: During the block's own reset (rst_ni low), the reset output is low and the count is zero. With the supply flag already high, release comes STRETCH_CYCLES+3 edges after rst_ni rises.
- R8: rst_active_o is always the logical inverse of sys_rst_no.
- R9: The stretch counter never exceeds STRETCH_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Block power-on reset, active low, asynchronous |
| supply_ok_i | input | 1 | Supply-above-threshold flag, high when good, asynchronous |
| man_rst_ni | input | 1 | Manual reset request, active low, asynchronous |
| sys_rst_no | output | 1 | System reset, active low, registered |
| rst_active_o | output | 1 | High while system reset is asserted, for watchdog gating |

## Verification
Each result has its own fixed latency, counted in rising edges from the negative clock edge where the bench changes an input:
- Assertion after a supply drop lands on edge 3: two synchroniser flops plus the phase register.
- Release after the supply flag rises lands on edge STRETCH_CYCLES+3.
- A qualified manual press takes effect on edge MIN_LOW_CYCLES+3.
- Release after the manual input returns lands on edge STRETCH_CYCLES+4, because the qualifier adds one register.

The bench drives on negative edges and samples the output on every negative edge across each window. This confirms both the exact edge of the change and the absence of any early release. It sweeps the brownout offset over the whole stretch and the manual pulse width across the qualification boundary.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    // Sequencer phase: held by a cause, counting out the stretch, or released.
    typedef enum logic [1:0] {
        PH_HOLD    = 2'd0,
        PH_STRETCH = 2'd1,
        PH_RUN     = 2'd2
    } phase_t;

    // Width needed to hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/rst_seq_qualify.sv
module rst_seq_qualify #(
    parameter int unsigned MIN_LOW_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_n_i,
    output logic press_o
);

    import rst_seq_pkg::*;

    localparam int unsigned QW = cnt_width(MIN_LOW_CYCLES);
    localparam logic [QW-1:0] LOW_SAT  = QW'(MIN_LOW_CYCLES);
    localparam logic [QW-1:0] LOW_NEED = QW'(MIN_LOW_CYCLES - 1);

    typedef struct packed {
        logic [QW-1:0] low_cnt;
        logic          pressed;
    } qual_state_t;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_n_i) begin
            st_d.low_cnt = '0;
            st_d.pressed = 1'b0;
        end else begin
            if (st_q.low_cnt != LOW_SAT) begin
                st_d.low_cnt = st_q.low_cnt + 1'b1;
            end
            st_d.pressed = st_q.pressed || (st_q.low_cnt >= LOW_NEED);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.low_cnt <= '0;
            st_q.pressed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign press_o = st_q.pressed;

    AST_PRESS_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.pressed) |-> $past(!req_n_i)) else $error("press without low input"); // R4

    AST_RELEASE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_n_i |=> !st_q.pressed) else $error("press held after release"); // R6

    AST_LOW_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.low_cnt <= LOW_SAT) else $error("low counter past limit"); // R5

endmodule

// File: rtl/rst_seq_stretch.sv
module rst_seq_stretch #(
    parameter int unsigned STRETCH_CYCLES = 6554,
    localparam int unsigned CW = rst_seq_pkg::cnt_width(STRETCH_CYCLES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    output logic          done_o,
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] LIMIT = CW'(STRETCH_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } str_state_t;

    str_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o  = (st_q.cnt == LIMIT);
    assign count_o = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LIMIT) else $error("stretch counter overflow"); // R9

    AST_CLEAR_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (st_q.cnt == '0)) else $error("count survived clear"); // R3

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int unsigned STRETCH_CYCLES = 6554,
    parameter int unsigned MIN_LOW_CYCLES = 2,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic supply_ok_i,
    input  logic man_rst_ni,
    output logic sys_rst_no,
    output logic rst_active_o
);

    import rst_seq_pkg::*;

    localparam int unsigned CW = cnt_width(STRETCH_CYCLES);

    typedef struct packed {
        phase_t phase;
    } top_state_t;

    logic          supply_s;
    logic          man_n_s;
    logic          press;
    logic          hold;
    logic          cnt_done;
    logic [CW-1:0] cnt_val;

    top_state_t st_d, st_q;

    rst_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_supply (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(supply_ok_i),
        .sync_o (supply_s)
    );

    rst_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_manual (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(man_rst_ni),
        .sync_o (man_n_s)
    );

    rst_seq_qualify #(.MIN_LOW_CYCLES(MIN_LOW_CYCLES)) u_qualify (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_n_i(man_n_s),
        .press_o(press)
    );

    assign hold = !supply_s || press;

    rst_seq_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(hold),
        .done_o (cnt_done),
        .count_o(cnt_val)
    );

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.phase = PH_HOLD;
        end else if (cnt_done) begin
            st_d.phase = PH_RUN;
        end else begin
            st_d.phase = PH_STRETCH;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst_no   = (st_q.phase == PH_RUN);
    assign rst_active_o = (st_q.phase != PH_RUN);

    AST_SUPPLY_DROP_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_s |=> !sys_rst_no) else $error("reset not asserted on low supply"); // R1

    AST_RELEASE_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_no) |-> $past(cnt_val) == CW'(STRETCH_CYCLES)) else $error("early release"); // R2

    AST_PRESS_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        press |=> !sys_rst_no) else $error("reset not asserted on press"); // R4

    AST_CNT_ZERO_WHILE_PRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        press |=> (cnt_val == '0)) else $error("counter moved during press"); // R6

    AST_STATUS_INVERSE: assert property (@(posedge clk_i)
        rst_active_o == !sys_rst_no) else $error("status not inverse of reset"); // R8

    AST_POR_STATE: assert property (@(posedge clk_i)
        !rst_ni |-> (!sys_rst_no && cnt_val == '0)) else $error("bad state in block reset"); // R7

endmodule

// File: tb/rst_seq_top_bench.sv
module rst_seq_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int S = 20;
    localparam int M = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic man_n = 1'b1;
    logic sys_rst_n;
    logic rst_active;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_top #(.STRETCH_CYCLES(S), .MIN_LOW_CYCLES(M)) u_rst_seq_top (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .supply_ok_i (supply_ok),
        .man_rst_ni  (man_n),
        .sys_rst_no  (sys_rst_n),
        .rst_active_o(rst_active)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (sys_rst_n !== exp) begin
            errors++;
            $display("FAIL %s sys_rst_no actual %b expected %b at %0t", req, sys_rst_n, exp, $time);
        end
        checks++;
        if (rst_active !== !exp) begin
            errors++;
            $display("FAIL R8 rst_active_o actual %b expected %b at %0t", rst_active, !exp, $time);
        end
    endtask

    // Check every negedge for n cycles: low before edge n, high at edge n.
    task automatic expect_release(input int n, input string req);
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            check((c >= n) ? 1'b1 : 1'b0, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R7: block reset state, supply already good
        repeat (3) @(negedge clk);
        check(1'b0, "R7");
        rst_n = 1'b1;
        expect_release(S + 3, "R7");

        // R1: supply drop asserts on edge 3
        @(negedge clk);
        supply_ok = 1'b0;
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check((c < 3) ? 1'b1 : 1'b0, "R1");
        end

        // R2: supply return, full stretch
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        expect_release(S + 3, "R2");

        // R3: one-cycle brownout at every offset of the stretch
        for (int off = 0; off <= S; off++) begin
            @(negedge clk);
            supply_ok = 1'b0;
            repeat (4) @(negedge clk);
            check(1'b0, "R3");
            supply_ok = 1'b1;
            for (int c = 1; c <= off; c++) begin
                @(negedge clk);
                check(1'b0, "R3");
            end
            supply_ok = 1'b0;
            @(negedge clk);
            supply_ok = 1'b1;
            expect_release(S + 3, "R3");
        end

        // R4/R5/R6: manual pulse width sweep, including a press longer than the stretch
        for (int k = 0; k < M + 4; k++) begin
            int len;
            len = (k < M + 3) ? k + 1 : S + 10;
            repeat (3) @(negedge clk);
            man_n = 1'b0;
            for (int c = 1; c <= len + S + 8; c++) begin
                logic exp;
                @(negedge clk);
                if (len < M) exp = 1'b1;
                else exp = (c < M + 3 || c >= len + S + 4) ? 1'b1 : 1'b0;
                if (len < M) check(exp, "R5");
                else if (c < len + 3) check(exp, "R4");
                else check(exp, "R6");
                if (c == len) man_n = 1'b1;
            end
        end

        // R6: press held across a supply return, release counted from manual release
        @(negedge clk);
        supply_ok = 1'b0;
        man_n = 1'b0;
        repeat (10) @(negedge clk);
        check(1'b0, "R6");
        supply_ok = 1'b1;
        for (int c = 1; c <= S + 6; c++) begin
            @(negedge clk);
            check(1'b0, "R6");
        end
        man_n = 1'b1;
        expect_release(S + 4, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule